// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is a parallel input port that a peripheral fills on its own initiative. The peripheral places a byte on the port pins and pulses an active-low strobe. The port acknowledges with a buffer-full flag, captures the byte when the strobe returns high, and then flags the processor with an interrupt request. The processor reads the byte with an active-low read strobe. Once that read completes, buffer-full clears and the peripheral may send the next byte.

Every step waits for the one before it. The interrupt request is withdrawn when a data read begins, and buffer-full drops only when that read ends. A processor-written enable bit gates the interrupt. A status view gives the interrupt, enable and buffer-full flags without moving the handshake along. Both asynchronous strobes pass through synchronisers, and all sequencing runs on the system clock.

Top module: `strobed_input_port`

## Requirements
- R1: A level change on `strobeN` or `readN` takes effect on the outputs three rising clock edges after it reaches the pin, and not at two edges.
- R2: With buffer-full clear, a falling edge of `strobeN` sets `bufFull` to 1.
- R3: The following rising edge of `strobeN` captures `pinData` into the holding register and raises the pending interrupt. `intReq` stays 0 while the strobe is still low.
- R4: A falling edge of `readN` with `regSel`=0, while a byte is pending, drives `intReq` to 0. `bufFull` stays 1.
- R5: The rising edge of `readN` that ends that data read clears `bufFull` to 0.
- R6: `intReq` is 1 only when the enable bit is 1 and a captured byte is unread. A clock edge with `cpuWrEn`=1 loads `cpuWrBit` into the enable bit, and the result is visible after that edge.
- R7: A strobe cycle that begins while `bufFull` is 1 is ignored. The held byte, `bufFull` and `intReq` keep their values.
- R8: With `regSel`=1, `cpuRdData` reads {zeros, intReq, enable, bufFull}, with intReq in bit 2, enable in bit 1 and bufFull in bit 0. A read strobe with `regSel`=1 changes no flag.
- R9: With `regSel`=0, `cpuRdData` shows the holding register.
- R10: A synchronous active-high `rst` clears `bufFull`, `intReq` and the enable bit, and sets the holding register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pinData | input | 8 | Byte presented by the peripheral |
| strobeN | input | 1 | Peripheral strobe, active low, asynchronous |
| bufFull | output | 1 | Buffer-full acknowledge to the peripheral |
| readN | input | 1 | Processor read strobe, active low, asynchronous |
| regSel | input | 1 | 0 selects data, 1 selects status; held steady through a read |
| cpuWrEn | input | 1 | Synchronous write pulse for the enable bit |
| cpuWrBit | input | 1 | Value written to the enable bit |
| cpuRdData | output | 8 | Read data: holding register or status |
| intReq | output | 1 | Interrupt request to the processor |

## Verification
Each handshake result is due three rising edges after its pin changes: two synchroniser stages and then the sequencing register. An enable write shows one edge after the write pulse. The bench drives every input on a falling clock edge and samples on a later falling edge, counted from the drive. For each handshake step it checks that the output has not yet moved after two edges and has moved after three. Captured bytes go into a scoreboard queue when they are sent and are compared when the processor-side read samples the data.

// File: rtl/sip_pkg.sv
package sip_pkg;
  // Handshake events seen in the clock domain
  typedef struct packed {
    logic strobeFall;
    logic strobeRise;
    logic readFall;
    logic readRise;
  } hsEvents_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLatch;
  } dpCtrl_t;
endpackage

// File: rtl/sip_edge_sync.sv
module sip_edge_sync #(
  parameter int STAGES = 2,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic fellEv,
  output logic roseEv
);
  logic [STAGES-1:0] chain;
  logic prevLevel;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= IDLE_LEVEL;
    else     chain[0] <= asyncIn;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= IDLE_LEVEL;
      else     chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prevLevel <= IDLE_LEVEL;
    else     prevLevel <= chain[STAGES-1];
  end

  assign fellEv = prevLevel & ~chain[STAGES-1];
  assign roseEv = ~prevLevel & chain[STAGES-1];
endmodule

// File: rtl/sip_datapath.sv
module sip_datapath
  import sip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pinData,
  input  logic              strobeN,
  input  logic              readN,
  input  logic              regSel,
  input  logic              cpuWrEn,
  input  logic              cpuWrBit,
  input  dpCtrl_t           ctrl,
  input  logic              intPending,
  input  logic              bufFull,
  output hsEvents_t         events,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              intReq
);
  localparam int PAD_W = DATA_W - 3;

  logic [DATA_W-1:0] dataLatch;
  logic              enableReg;

  sip_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_strobeSync (
    .clk(clk), .rst(rst), .asyncIn(strobeN),
    .fellEv(events.strobeFall), .roseEv(events.strobeRise)
  );

  sip_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_readSync (
    .clk(clk), .rst(rst), .asyncIn(readN),
    .fellEv(events.readFall), .roseEv(events.readRise)
  );

  always_ff @(posedge clk) begin
    if (rst)                dataLatch <= '0;
    else if (ctrl.loadLatch) dataLatch <= pinData;
  end

  always_ff @(posedge clk) begin
    if (rst)          enableReg <= 1'b0;
    else if (cpuWrEn) enableReg <= cpuWrBit;
  end

  assign intReq = intPending & enableReg;

  always_comb begin
    if (regSel) cpuRdData = {{PAD_W{1'b0}}, intReq, enableReg, bufFull};
    else        cpuRdData = dataLatch;
  end

  // R6
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(enableReg) |-> $past(cpuWrEn));

  // R7
  latch_only_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dataLatch) |-> $past(ctrl.loadLatch));
endmodule

// File: rtl/sip_control.sv
module sip_control
  import sip_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  hsEvents_t events,
  input  logic      regSel,
  output dpCtrl_t   ctrl,
  output logic      bufFull,
  output logic      intPending
);
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACKED,
    ST_HELD,
    ST_DRAIN
  } hsState_t;

  hsState_t state, stateNext;

  always_comb begin
    stateNext      = state;
    ctrl.loadLatch = 1'b0;
    unique case (state)
      ST_IDLE:  if (events.strobeFall) stateNext = ST_ACKED;
      ST_ACKED: if (events.strobeRise) begin
                  stateNext      = ST_HELD;
                  ctrl.loadLatch = 1'b1;
                end
      ST_HELD:  if (events.readFall && !regSel) stateNext = ST_DRAIN;
      ST_DRAIN: if (events.readRise) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign bufFull    = (state != ST_IDLE);
  assign intPending = (state == ST_HELD);

  // R2
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!bufFull && events.strobeFall) |=> bufFull);

  // R3
  int_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(intPending) |-> $past(events.strobeRise));

  // R4
  int_drop_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(intPending) |-> $past(events.readFall && !regSel));

  // R5
  full_clear_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bufFull) |-> $past(events.readRise));
endmodule

// File: rtl/strobed_input_port.sv
module strobed_input_port
  import sip_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] pinData,
  input  logic              strobeN,
  output logic              bufFull,
  input  logic              readN,
  input  logic              regSel,
  input  logic              cpuWrEn,
  input  logic              cpuWrBit,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              intReq
);
  hsEvents_t events;
  dpCtrl_t   ctrl;
  logic      intPending;

  sip_control u_control (
    .clk(clk), .rst(rst), .events(events), .regSel(regSel),
    .ctrl(ctrl), .bufFull(bufFull), .intPending(intPending)
  );

  sip_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk(clk), .rst(rst), .pinData(pinData), .strobeN(strobeN),
    .readN(readN), .regSel(regSel), .cpuWrEn(cpuWrEn), .cpuWrBit(cpuWrBit),
    .ctrl(ctrl), .intPending(intPending), .bufFull(bufFull),
    .events(events), .cpuRdData(cpuRdData), .intReq(intReq)
  );
endmodule

// File: tb/strobed_input_port_tb.sv
module strobed_input_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pinData = 8'h00;
  logic       strobeN = 1'b1;
  logic       readN = 1'b1;
  logic       regSel = 1'b0;
  logic       cpuWrEn = 1'b0;
  logic       cpuWrBit = 1'b0;
  logic       bufFull;
  logic [7:0] cpuRdData;
  logic       intReq;

  int total = 0;
  int bad = 0;
  logic [7:0] expQ[$];
  event sampleEv;

  always #4 clk = ~clk;

  strobed_input_port u_dut (
    .clk(clk), .rst(rst), .pinData(pinData), .strobeN(strobeN),
    .bufFull(bufFull), .readN(readN), .regSel(regSel), .cpuWrEn(cpuWrEn),
    .cpuWrBit(cpuWrBit), .cpuRdData(cpuRdData), .intReq(intReq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: compares data reads against queued bytes
  initial begin
    forever begin
      @(sampleEv);
      if (expQ.size() == 0) check("R9 empty-queue", cpuRdData, 8'hxx);
      else check("R9 data read", cpuRdData, expQ.pop_front());
    end
  end

  task automatic writeEnable(logic v);
    cpuWrBit = v; cpuWrEn = 1'b1;
    waitN(1);
    cpuWrEn = 1'b0;
  endtask

  // Peripheral strobe cycle; accepted bytes go to the scoreboard
  task automatic sendByte(logic [7:0] d, bit accepted);
    pinData = d;
    strobeN = 1'b0;
    waitN(3);
    strobeN = 1'b1;
    waitN(3);
    if (accepted) expQ.push_back(d);
  endtask

  task automatic readData();
    regSel = 1'b0; readN = 1'b0;
    waitN(3);
    -> sampleEv;
    check("R4 intReq drop", {7'd0, intReq}, 8'd0);
    check("R4 bufFull held", {7'd0, bufFull}, 8'd1);
    waitN(1);
    readN = 1'b1;
    waitN(3);
    check("R5 bufFull clear", {7'd0, bufFull}, 8'd0);
  endtask

  initial begin
    fork
      begin
        waitN(20000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    waitN(4);
    rst = 1'b0;
    waitN(1);
    // R10 reset state
    check("R10 bufFull", {7'd0, bufFull}, 8'd0);
    check("R10 intReq", {7'd0, intReq}, 8'd0);
    check("R10 latch", cpuRdData, 8'h00);
    regSel = 1'b1; waitN(1);
    check("R10 status", cpuRdData, 8'h00);

    writeEnable(1'b1);
    check("R6 enable visible", cpuRdData, 8'h02);
    regSel = 1'b0;

    // R1/R2: exact latency of strobe fall
    pinData = 8'h7A; strobeN = 1'b0;
    waitN(2);
    check("R1 not yet at 2 edges", {7'd0, bufFull}, 8'd0);
    waitN(1);
    check("R2 bufFull set", {7'd0, bufFull}, 8'd1);
    waitN(3);
    check("R3 no intReq while strobe low", {7'd0, intReq}, 8'd0);
    strobeN = 1'b1;
    waitN(2);
    check("R1 intReq not at 2 edges", {7'd0, intReq}, 8'd0);
    waitN(1);
    check("R3 intReq raised", {7'd0, intReq}, 8'd1);
    check("R9 latch shows byte", cpuRdData, 8'h7A);
    expQ.push_back(8'h7A);

    // R8 status read leaves handshake alone
    regSel = 1'b1; readN = 1'b0;
    waitN(4);
    check("R8 status during read", cpuRdData, 8'h07);
    readN = 1'b1;
    waitN(4);
    check("R8 intReq kept", {7'd0, intReq}, 8'd1);
    check("R8 bufFull kept", {7'd0, bufFull}, 8'd1);
    regSel = 1'b0;
    readData();

    // R7: second strobe while full is ignored
    sendByte(8'hE5, 1'b1);
    sendByte(8'h3C, 1'b0);
    check("R7 bufFull kept", {7'd0, bufFull}, 8'd1);
    check("R7 intReq kept", {7'd0, intReq}, 8'd1);
    check("R7 latch kept", cpuRdData, 8'hE5);
    readData();

    // R6: disabled interrupt then enable
    writeEnable(1'b0);
    sendByte(8'h91, 1'b1);
    check("R6 intReq gated", {7'd0, intReq}, 8'd0);
    check("R6 bufFull set", {7'd0, bufFull}, 8'd1);
    writeEnable(1'b1);
    check("R6 intReq after enable", {7'd0, intReq}, 8'd1);
    readData();

    // Varied byte patterns
    for (int i = 0; i < 4; i++) begin
      sendByte(8'h11 << i ^ 8'hA0, 1'b1);
      readData();
    end

    // R10 reset mid-transaction
    sendByte(8'h5F, 1'b0);
    rst = 1'b1; waitN(2); rst = 1'b0; waitN(1);
    check("R10 bufFull after reset", {7'd0, bufFull}, 8'd0);
    check("R10 intReq after reset", {7'd0, intReq}, 8'd0);
    check("R10 latch after reset", cpuRdData, 8'h00);
    regSel = 1'b1; waitN(1);
    check("R10 enable after reset", cpuRdData, 8'h00);
    check("R9 queue drained", 8'(expQ.size()), 8'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule